// File: doc/BRIEF.md
# Grounded-Switch Successive-Approximation Conversion Controller

This block sequences an 11-bit charge-redistribution converter. The converter's capacitor lines only ever see the high rail or the low rail. The search does not compare the input against a reference level made by a DAC. Instead, the sampled charge is kept on the array, and the comparator tests that charge against a fixed half-supply threshold. Between tests the controller adds or removes binary-weighted charge by flipping one capacitor line at a time.

After a start request in idle, the controller closes the sampling switch. It holds the sample pattern, with only the top line high, for a set number of cycles. It then opens the switch and tests the top line. Each test is a two-cycle pair. In the first cycle the comparator is in its compare phase and its decision is taken at the edge. In the second cycle the comparator is back in reset, the resolved line is parked, and the next lower line is raised. After the lowest bit resolves, a one-cycle done pulse presents the code, and the controller returns to idle with every line low.

Top module: `sar_redist_ctrl`

## Requirements
- R1: A synchronous active-high reset leaves `samp_en`, `cmp_phase` and `done` at 0, every `cap_drive` line at 0 (low rail) and `code` at 0 from the following cycle.
- R2: After `start` is seen in idle, `samp_en` is 1 for exactly SAMPLE_CYCLES cycles. During those cycles `cap_drive` has only line NBITS-1 at 1 (high rail), and `cmp_phase` is 0.
- R3: The cycle after sampling has `samp_en` at 0 and `cmp_phase` at 1 (compare), with line NBITS-1 at the high rail as the first bit under test.
- R4: A compare-phase decision of `cmp_above`=1 (array above half supply) resolves the tested bit to 1 and puts its line at the low rail from the next cycle.
- R5: A compare-phase decision of `cmp_above`=0 resolves the tested bit to 0 and leaves its line at the high rail.
- R6: Each decision except the last is followed by exactly one cycle with `cmp_phase`=0 (comparator reset). In that cycle the next lower line is already at the high rail, and `cmp_phase` returns to 1 on the next cycle.
- R7: `cmp_above` has no effect on the outputs in any cycle where `cmp_phase` is 0.
- R8: Resolving bit 0 is followed by exactly one cycle of `done`=1. In that cycle and afterwards, `code` holds the result (bit k = decision for line k), and the next cycle is idle with all lines low.
- R9: `start` has no effect while a conversion is in progress.
- R10: With the array modelled as the sampled input plus and minus binary-weighted steps, the code equals the ideal quantisation of the input, including both rails and exactly mid-supply.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Conversion clock; decisions are taken on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Conversion request, honoured only in idle |
| cmp_above | input | 1 | Comparator decision: 1 = array above half supply |
| samp_en | output | 1 | Sampling switch enable (1 = switch closed) |
| cmp_phase | output | 1 | Comparator phase: 1 = compare, 0 = reset |
| cap_drive | output | NBITS | Per-capacitor rail select, 1 = high rail, 0 = low rail; index NBITS-1 is the most significant |
| code | output | NBITS | Result of the last finished conversion |
| done | output | 1 | One-cycle pulse when a new code is presented |

## Verification
The bench builds the block with NBITS=11 and SAMPLE_CYCLES=3. The odd sample length is used so that a timeline fixed to the default of two cycles would misplace every later phase. The full 11-bit width lets the behavioural array model reach both rails and the exact half-supply point, 1024, where the top decision sits on the threshold. Outside the compare phase the bench feeds the inverted comparator value, so any leak of the reset-phase decision changes the code or the line pattern.

// File: rtl/sar_ctrl_pkg.sv
package sar_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_SAMPLE  = 3'd1,
    ST_COMPARE = 3'd2,
    ST_CRESET  = 3'd3,
    ST_DONE    = 3'd4
  } sar_state_e;

  // Rail chosen for a tested line once resolved: opposite sense of the decision.
  function automatic logic park_rail(input logic above);
    return ~above;
  endfunction

endpackage

// File: rtl/sar_seq.sv
module sar_seq
  import sar_ctrl_pkg::*;
#(
  parameter int SAMPLE_CYCLES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       last_bit,
  output sar_state_e st_q,
  output logic       ev_accept,
  output logic       ev_sample_end,
  output logic       ev_decide,
  output logic       ev_finish
);
  localparam int CW = (SAMPLE_CYCLES < 2) ? 1 : $clog2(SAMPLE_CYCLES);
  localparam logic [CW-1:0] CNT_LAST = CW'(SAMPLE_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  sar_state_e    st_d;

  assign ev_accept     = (st_q == ST_IDLE) && start;
  assign ev_sample_end = (st_q == ST_SAMPLE) && (cnt_q == CNT_LAST);
  assign ev_decide     = (st_q == ST_COMPARE);
  assign ev_finish     = ev_decide && last_bit;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:    if (start) st_d = ST_SAMPLE;
      ST_SAMPLE:  if (ev_sample_end) st_d = ST_COMPARE;
      ST_COMPARE: st_d = last_bit ? ST_DONE : ST_CRESET;
      ST_CRESET:  st_d = ST_COMPARE;
      ST_DONE:    st_d = ST_IDLE;
      default:    st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_SAMPLE) cnt_q <= cnt_q + 1'b1;
      else                   cnt_q <= '0;
    end
  end
endmodule

// File: rtl/sar_ptr.sv
module sar_ptr #(
  parameter int NBITS = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ev_sample_end,
  input  logic             ev_decide,
  output logic [NBITS-1:0] ptr_q,
  output logic             last_bit
);
  localparam logic [NBITS-1:0] TOP_ONEHOT = {1'b1, {(NBITS-1){1'b0}}};

  assign last_bit = ptr_q[0];

  always_ff @(posedge clk) begin
    if (rst)                ptr_q <= '0;
    else if (ev_sample_end) ptr_q <= TOP_ONEHOT;
    else if (ev_decide)     ptr_q <= ptr_q >> 1;
  end
endmodule

// File: rtl/sar_lines.sv
module sar_lines
  import sar_ctrl_pkg::*;
#(
  parameter int NBITS = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ev_accept,
  input  logic             ev_decide,
  input  logic             ev_finish,
  input  logic             in_done,
  input  logic             cmp_above,
  input  logic [NBITS-1:0] ptr_q,
  output logic [NBITS-1:0] cap_drive,
  output logic [NBITS-1:0] code_q
);
  logic [NBITS-1:0] work_q;
  logic [NBITS-1:0] work_d;

  // Bit value gathered so far, including the decision of this cycle.
  assign work_d = work_q | (ptr_q & {NBITS{cmp_above & ev_decide}});

  for (genvar k = 0; k < NBITS; k++) begin : g_line
    localparam logic SAMPLE_LVL = (k == NBITS - 1);
    logic raise_next;
    if (k == NBITS - 1) begin : g_top
      assign raise_next = 1'b0;
    end else begin : g_low
      assign raise_next = ptr_q[k+1];
    end

    always_ff @(posedge clk) begin
      if (rst)
        cap_drive[k] <= 1'b0;
      else if (ev_accept)
        cap_drive[k] <= SAMPLE_LVL;
      else if (ev_decide && ptr_q[k])
        cap_drive[k] <= park_rail(cmp_above);
      else if (ev_decide && raise_next)
        cap_drive[k] <= 1'b1;
      else if (in_done)
        cap_drive[k] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      work_q <= '0;
      code_q <= '0;
    end else begin
      if (ev_accept)      work_q <= '0;
      else if (ev_decide) work_q <= work_d;
      if (ev_finish)      code_q <= work_d;
    end
  end
endmodule

// File: rtl/sar_redist_ctrl.sv
module sar_redist_ctrl
  import sar_ctrl_pkg::*;
#(
  parameter int NBITS         = 11,
  parameter int SAMPLE_CYCLES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             cmp_above,
  output logic             samp_en,
  output logic             cmp_phase,
  output logic [NBITS-1:0] cap_drive,
  output logic [NBITS-1:0] code,
  output logic             done
);
  sar_state_e       st_q;
  logic             ev_accept;
  logic             ev_sample_end;
  logic             ev_decide;
  logic             ev_finish;
  logic             last_bit;
  logic [NBITS-1:0] ptr_q;

  sar_seq #(.SAMPLE_CYCLES(SAMPLE_CYCLES)) u_seq (
    .clk           (clk),
    .rst           (rst),
    .start         (start),
    .last_bit      (last_bit),
    .st_q          (st_q),
    .ev_accept     (ev_accept),
    .ev_sample_end (ev_sample_end),
    .ev_decide     (ev_decide),
    .ev_finish     (ev_finish)
  );

  sar_ptr #(.NBITS(NBITS)) u_ptr (
    .clk           (clk),
    .rst           (rst),
    .ev_sample_end (ev_sample_end),
    .ev_decide     (ev_decide),
    .ptr_q         (ptr_q),
    .last_bit      (last_bit)
  );

  sar_lines #(.NBITS(NBITS)) u_lines (
    .clk       (clk),
    .rst       (rst),
    .ev_accept (ev_accept),
    .ev_decide (ev_decide),
    .ev_finish (ev_finish),
    .in_done   (st_q == ST_DONE),
    .cmp_above (cmp_above),
    .ptr_q     (ptr_q),
    .cap_drive (cap_drive),
    .code_q    (code)
  );

  assign samp_en   = (st_q == ST_SAMPLE);
  assign cmp_phase = (st_q == ST_COMPARE);
  assign done      = (st_q == ST_DONE);
endmodule

// File: rtl/sar_ctrl_chk.sv
module sar_ctrl_chk #(
  parameter int NBITS = 11
) (
  input logic             clk,
  input logic             rst,
  input logic             cmp_above,
  input logic             samp_en,
  input logic             cmp_phase,
  input logic [NBITS-1:0] cap_drive,
  input logic             done,
  input logic [NBITS-1:0] ptr_q
);
  localparam logic [NBITS-1:0] TOP_ONEHOT = {1'b1, {(NBITS-1){1'b0}}};

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (!samp_en && !cmp_phase && !done && cap_drive == '0));

  // R2
  sample_pattern_chk: assert property (@(posedge clk) disable iff (rst)
    samp_en |-> (cap_drive == TOP_ONEHOT && !cmp_phase));

  // R3
  hold_first_test_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(samp_en) |-> (cmp_phase && ptr_q == TOP_ONEHOT && cap_drive[NBITS-1]));

  // R4
  decide_one_chk: assert property (@(posedge clk) disable iff (rst)
    (cmp_phase && cmp_above) |=> ((cap_drive & $past(ptr_q)) == '0));

  // R5
  decide_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (cmp_phase && !cmp_above) |=> ((cap_drive & $past(ptr_q)) == $past(ptr_q)));

  // R6
  reset_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (cmp_phase && !ptr_q[0]) |=> (!cmp_phase && !done && (cap_drive & $past(ptr_q >> 1)) != '0));

  // R6
  pointer_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ptr_q));

  // R8
  done_after_last_chk: assert property (@(posedge clk) disable iff (rst)
    (cmp_phase && ptr_q[0]) |=> done);

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> (!done && cap_drive == '0 && !cmp_phase));

  // R9
  no_resample_chk: assert property (@(posedge clk) disable iff (rst)
    cmp_phase |=> !samp_en);
endmodule

bind sar_redist_ctrl sar_ctrl_chk #(.NBITS(NBITS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmp_above (cmp_above),
  .samp_en   (samp_en),
  .cmp_phase (cmp_phase),
  .cap_drive (cap_drive),
  .done      (done),
  .ptr_q     (ptr_q)
);

// File: tb/sar_redist_ctrl_bench.sv
`timescale 1ns/1ps
module sar_redist_ctrl_bench;
  localparam int N = 11;
  localparam int S = 3;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic         cmp_above;
  logic         samp_en;
  logic         cmp_phase;
  logic [N-1:0] cap_drive;
  logic [N-1:0] code;
  logic         done;

  int vin = 0;
  int nchk = 0;
  int nfail = 0;
  int last_code = 0;

  always #2 clk = ~clk;

  sar_redist_ctrl #(.NBITS(N), .SAMPLE_CYCLES(S)) u_sar_redist_ctrl (
    .clk(clk), .rst(rst), .start(start), .cmp_above(cmp_above),
    .samp_en(samp_en), .cmp_phase(cmp_phase), .cap_drive(cap_drive),
    .code(code), .done(done)
  );

  // Array model in half-LSB units: sampled input plus or minus binary steps
  // relative to the sample pattern, tested against half of full scale.
  function automatic bit array_above(input int x, input logic [N-1:0] d);
    int v = 2 * x + 1;
    for (int k = 0; k < N; k++) begin
      int now_hi = d[k] ? 1 : 0;
      int smp_hi = (k == N - 1) ? 1 : 0;
      v += 2 * (now_hi - smp_hi) * (1 << k);
    end
    return v > (1 << N);
  endfunction

  // R7: outside compare the comparator output is junk (inverted decision).
  always_comb begin
    if (cmp_phase) cmp_above = array_above(vin, cap_drive);
    else           cmp_above = ~array_above(vin, cap_drive);
  end

  // Expected rail pattern: lines above b parked by their code bit, b high, rest low.
  function automatic logic [N-1:0] lines_for(input int x, input int b);
    logic [N-1:0] r = '0;
    for (int k = 0; k < N; k++) begin
      if (k > b)       r[k] = ((x >> k) & 1) == 0;
      else if (k == b) r[k] = 1'b1;
    end
    return r;
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic chk_all(input string tag, input int e_smp, input int e_cph,
                         input int e_drv, input int e_done, input int e_code);
    chk(tag, "samp_en",   int'(samp_en),   e_smp);
    chk(tag, "cmp_phase", int'(cmp_phase), e_cph);
    chk(tag, "cap_drive", int'(cap_drive), e_drv);
    chk(tag, "done",      int'(done),      e_done);
    chk(tag, "code",      int'(code),      e_code);
  endtask

  task automatic run_conv(input int x, input bit noisy);
    int total = S + 2 * N;
    vin = x;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int off = 0; off < total; off++) begin
      if (off < S) begin
        chk_all("R2", 1, 0, 1 << (N - 1), 0, last_code);
      end else begin
        int j = off - S;
        if (j == 2 * N - 1) begin
          chk_all("R8", 0, 0, int'(lines_for(x, -1)), 1, x);
          chk(noisy ? "R9" : "R10", "final code", int'(code), x);
        end else begin
          int b = N - 1 - (j + 1) / 2;
          string tg;
          if (j == 0)          tg = "R3";
          else if (j % 2 == 0) tg = "R4 R5";
          else                 tg = "R6 R7";
          chk_all(tg, 0, (j % 2 == 0) ? 1 : 0, int'(lines_for(x, b)), 0, last_code);
        end
      end
      start = (noisy && (off == S + 2 || off == S + 3)) ? 1'b1 : 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    last_code = x;
    chk_all("R8", 0, 0, 0, 0, x);
    @(negedge clk);
    chk_all("R9", 0, 0, 0, 0, x);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk_all("R1", 0, 0, 0, 0, 0);
    rst = 1'b0;
    @(negedge clk);
    chk_all("R1", 0, 0, 0, 0, 0);

    run_conv(0, 1'b0);            // low rail, R10
    run_conv((1 << N) - 1, 1'b0); // high rail, R10
    run_conv(1 << (N - 1), 1'b0); // exactly mid-supply, R10
    run_conv((1 << (N - 1)) - 1, 1'b0);
    run_conv(1, 1'b0);
    run_conv(12'h555 & ((1 << N) - 1), 1'b0);
    run_conv(12'h2AA & ((1 << N) - 1), 1'b1); // start pulsed mid-conversion, R9
    run_conv(3 << (N - 2), 1'b0);
    begin
      int seed = 17;
      for (int t = 0; t < 6; t++) begin
        seed = (seed * 1103 + 12345) % 65536;
        run_conv(seed % (1 << N), t[0]);
      end
    end

    // R1: reset in the middle of a conversion
    vin = 700;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (8) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk_all("R1", 0, 0, 0, 0, 0);
    last_code = 0;
    @(negedge clk);
    chk_all("R1", 0, 0, 0, 0, 0);
    run_conv(700, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule